// File: doc/BRIEF.md
# Framed Two-Bit-Per-Cycle Word Serializer

The block turns 12-bit parallel sample words into a serial stream. Two bits leave on every cycle of the bit-rate clock: an early bit for the first half-cycle and a late bit for the second. A word period therefore lasts six clock cycles. The block also produces a word-rate frame clock whose rising edge marks the first bit of each frame.

A single-cycle word strobe, one cycle before the first slot of each frame, loads the next word. A small register port selects what is sent. The choices are live sample data, an alternating deskew pattern, a sync pattern (six zeros then six ones), or a programmed custom word.

The output double-data-rate flop, the differential buffers and the clock generation lie outside the block. The outputs are a 2-bit lane pair for the edge flop and the frame clock, both sampled per bit-rate clock cycle.

Top module: `frame_serializer`

## Requirements
- R1: While reset is held and after it is released, bit_pair is 0, frame_clk is 0 and the selected mode is normal (0) until the first word strobe.
- R2: A strobe sampled at clock edge E loads a frame. In the j-th cycle after E (j = 0..5), bit_pair[1] carries word bit 11-2j (the earlier bit) and bit_pair[0] carries bit 10-2j, so the word goes out MSB first.
- R3: frame_clk is 1 in cycles 0, 1 and 2 of a frame and 0 in cycles 3, 4 and 5.
- R4: A write to address 0 sets the mode from cfg_wdata[1:0]: 0 normal (word_in is sent), 1 deskew, 2 sync, 3 custom.
- R5: Deskew mode sends 12'h555, the bits 0,1,0,1,... in time order, whatever word_in holds.
- R6: Sync mode sends 12'h03F, six 0 bits followed by six 1 bits, whatever word_in holds.
- R7: A write to address 1 stores cfg_wdata[11:0] as the custom word, which custom mode sends in place of word_in.
- R8: Mode and custom word are sampled at the strobe edge. A write made during cycles 0..4 of a frame leaves that frame unchanged and applies from the next frame on.
- R9: Writes to addresses 2 and 3 change nothing that is sent.
- R10: If no strobe arrives at the end of cycle 5, the line goes idle: bit_pair 0 and frame_clk 0 until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, six cycles per word |
| rst_n | input | 1 | Synchronous active-low reset |
| word_stb | input | 1 | One-cycle strobe that loads the next frame |
| word_in | input | 12 | Parallel sample word, captured with the strobe |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 12 | Register write data |
| bit_pair | output | 2 | [1] earlier bit, [0] later bit of the current cycle |
| frame_clk | output | 1 | Word-rate frame clock, high for the first half of a frame |

## Verification
The assertions assume that strobes arrive either in the last cycle of a running frame or while the line is idle, never in the middle of a frame. The bench keeps to this by raising the strobe only at the end of a six-cycle frame or after an idle gap. Register writes are placed at random slots 0 to 4 of a frame, never on the strobe cycle, so the frame each write first affects is always the next one. Data, addresses and write values are drawn at random, and the reserved addresses are hit along with the live ones.

// File: rtl/ser_pkg.sv
// Shared types for the framed serializer.
// Assumes a 2-bit mode field; encoding values are visible at the register port.
package ser_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_DESKEW = 2'd1,
        MODE_SYNC   = 2'd2,
        MODE_CUSTOM = 2'd3
    } mode_e;

    localparam logic [1:0] ADDR_MODE   = 2'd0;
    localparam logic [1:0] ADDR_CUSTOM = 2'd1;
endpackage

// File: rtl/ser_cfg_regs.sv
// Configuration registers: mode select and custom word.
// Assumes one write per cycle; unmapped addresses are dropped; reset clears all to 0.
module ser_cfg_regs #(
    parameter int WORD_W = 12,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output ser_pkg::mode_e      mode,
    output logic [WORD_W-1:0]   custom
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ser_pkg::ADDR_MODE);
    localparam logic [ADDR_W-1:0] A_CUST = ADDR_W'(ser_pkg::ADDR_CUSTOM);

    // Register update on writes to mapped addresses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= ser_pkg::MODE_NORMAL;
            custom <= '0;
        end else if (we) begin
            if (addr == A_MODE) begin
                mode <= ser_pkg::mode_e'(wdata[1:0]);
            end
            if (addr == A_CUST) begin
                custom <= wdata;
            end
        end
    end
endmodule

// File: rtl/ser_pattern_sel.sv
// Selects the word to be serialized: live data or one of the test patterns.
// Deskew and sync words are built per bit by generate loops, MSB sent first.
module ser_pattern_sel #(
    parameter int WORD_W = 12
) (
    input  ser_pkg::mode_e      mode,
    input  logic [WORD_W-1:0]   data,
    input  logic [WORD_W-1:0]   custom,
    output logic [WORD_W-1:0]   word
);
    logic [WORD_W-1:0] deskew_w;
    logic [WORD_W-1:0] sync_w;

    // Deskew: bit i is 1 when i is even, so time order starts 0,1,0,1.
    // Sync: low half of the word is 1, so the first half in time is 0.
    for (genvar i = 0; i < WORD_W; i++) begin : g_pat
        assign deskew_w[i] = ((i % 2) == 0);
        assign sync_w[i]   = (i < WORD_W / 2);
    end

    // Mode multiplexer.
    always_comb begin
        unique case (mode)
            ser_pkg::MODE_DESKEW: word = deskew_w;
            ser_pkg::MODE_SYNC:   word = sync_w;
            ser_pkg::MODE_CUSTOM: word = custom;
            default:              word = data;
        endcase
    end
endmodule

// File: rtl/ser_shift_out.sv
// Holding/shift register that sends LANE_W bits per clock, MSB first, and the frame clock.
// Assumes strobes come only in the final slot of a frame or while idle.
module ser_shift_out #(
    parameter int WORD_W = 12,
    parameter int LANE_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic [WORD_W-1:0]   word,
    input  ser_pkg::mode_e      mode_in,
    output logic [LANE_W-1:0]   lane,
    output logic                fclk,
    output ser_pkg::mode_e      mode_act
);
    localparam int SLOTS = WORD_W / LANE_W;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(SLOTS / 2);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  slot;
    logic              active;

    // Load on strobe, shift each cycle, fall idle after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            slot     <= '0;
            active   <= 1'b0;
            mode_act <= ser_pkg::MODE_NORMAL;
        end else if (stb) begin
            shreg    <= word;
            slot     <= '0;
            active   <= 1'b1;
            mode_act <= mode_in;
        end else if (active) begin
            if (slot == LAST) begin
                shreg  <= '0;
                active <= 1'b0;
            end else begin
                shreg <= shreg << LANE_W;
                slot  <= slot + 1'b1;
            end
        end
    end

    // Output taps: top bits of the shift register and the half-frame flag.
    always_comb begin
        lane = shreg[WORD_W-1 -: LANE_W];
        fclk = active && (slot < HALF);
    end
endmodule

// File: rtl/frame_serializer.sv
// Top level: configuration registers, pattern selection and the two-bit-per-cycle shifter.
// Assumes clk is the bit-rate clock (six cycles per word) and word_stb is a one-cycle pulse.
module frame_serializer #(
    parameter int WORD_W = 12,
    parameter int LANE_W = 2,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_stb,
    input  logic [WORD_W-1:0]   word_in,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic [LANE_W-1:0]   bit_pair,
    output logic                frame_clk
);
    ser_pkg::mode_e     cfg_mode;
    ser_pkg::mode_e     act_mode;
    logic [WORD_W-1:0]  cfg_custom;
    logic [WORD_W-1:0]  sel_word;

    ser_cfg_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .mode(cfg_mode), .custom(cfg_custom)
    );

    ser_pattern_sel #(.WORD_W(WORD_W)) u_sel (
        .mode(cfg_mode), .data(word_in), .custom(cfg_custom), .word(sel_word)
    );

    ser_shift_out #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .stb(word_stb), .word(sel_word),
        .mode_in(cfg_mode), .lane(bit_pair), .fclk(frame_clk), .mode_act(act_mode)
    );
endmodule

// File: rtl/frame_serializer_chk.sv
// Checker for frame_serializer: keeps its own slot counter from the strobe
// and checks the frame clock, idle line, test patterns and register behaviour.
module frame_serializer_chk #(
    parameter int WORD_W = 12,
    parameter int LANE_W = 2,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_stb,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [LANE_W-1:0]   bit_pair,
    input  logic                frame_clk,
    input  ser_pkg::mode_e      act_mode,
    input  ser_pkg::mode_e      cfg_mode,
    input  logic [WORD_W-1:0]   cfg_custom
);
    localparam int SLOTS = WORD_W / LANE_W;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(SLOTS / 2);

    function automatic logic [LANE_W-1:0] dsk_lane();
        logic [LANE_W-1:0] v;
        for (int i = 0; i < LANE_W; i++) v[i] = ((i % 2) == 0);
        return v;
    endfunction
    localparam logic [LANE_W-1:0] DSK = dsk_lane();

    logic [CNT_W-1:0] sc;

    // Independent slot count since the last strobe, IDLE when no frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n)        sc <= IDLE;
        else if (word_stb) sc <= '0;
        else if (sc < IDLE) sc <= sc + 1'b1;
    end

    // R3
    frame_clk_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_clk == (sc < HALF));
    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc == IDLE) |-> (bit_pair == '0 && !frame_clk));
    // R6
    sync_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == ser_pkg::MODE_SYNC && sc < IDLE) |-> (bit_pair == ((sc < HALF) ? '0 : '1)));
    // R5
    deskew_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == ser_pkg::MODE_DESKEW && sc < IDLE) |-> (bit_pair == DSK));
    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |=> $stable(act_mode));
    // R9
    reserved_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > ADDR_W'(1)) |=> ($stable(cfg_mode) && $stable(cfg_custom)));
    // R2
    stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> (sc == IDLE || sc == IDLE - 1'b1));
endmodule

bind frame_serializer frame_serializer_chk #(.WORD_W(WORD_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .bit_pair(bit_pair), .frame_clk(frame_clk), .act_mode(act_mode),
    .cfg_mode(cfg_mode), .cfg_custom(cfg_custom)
);

// File: tb/tb_frame_serializer.sv
`timescale 1ns/1ps
module tb_frame_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_stb = 1'b0;
    logic [11:0] word_in = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [1:0]  bit_pair;
    logic        frame_clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0]  m_mode = 2'd0;
    logic [11:0] m_cust = '0;

    always #2 clk = ~clk;

    frame_serializer dut (
        .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_in(word_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bit_pair(bit_pair), .frame_clk(frame_clk)
    );

    function automatic logic [11:0] expect_word(logic [1:0] md, logic [11:0] cu, logic [11:0] d);
        case (md)
            2'd1:    return 12'h555;
            2'd2:    return 12'h03F;
            2'd3:    return cu;
            default: return d;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [1:0] a, logic [11:0] d);
        if (a == 2'd0) m_mode = d[1:0];
        else if (a == 2'd1) m_cust = d;
    endtask

    // Sends one frame starting at a negedge; optional write at slot wk (0..4, -1 none).
    task automatic frame(logic [11:0] d, int wk, logic [1:0] wa, logic [11:0] wd, string tag);
        logic [11:0] exp;
        exp = expect_word(m_mode, m_cust, d);
        word_stb = 1'b1;
        word_in  = d;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (i == 0) word_stb = 1'b0;
            cfg_we = 1'b0;
            chk(bit_pair == exp[11-2*i -: 2], {tag, " R2 pair"}, {10'd0, bit_pair}, {10'd0, exp[11-2*i -: 2]});
            chk(frame_clk == (i < 3), "R3 frame_clk", {11'd0, frame_clk}, {11'd0, 1'(i < 3)});
            if (i == wk) begin
                cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
                model_write(wa, wd);
            end
        end
    endtask

    task automatic idle_cycle(string tag);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(bit_pair == 2'b00 && !frame_clk, tag, {9'd0, frame_clk, bit_pair}, 12'd0);
    endtask

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        chk(bit_pair == 2'b00 && !frame_clk, "R1 in reset", {9'd0, frame_clk, bit_pair}, 12'd0);
        rst_n = 1'b1;
        idle_cycle("R1 after reset");
        idle_cycle("R1 idle");
        // R1 R4: default mode is normal
        frame(12'hA5C, -1, 2'd0, 12'd0, "R1 normal default");
        frame(12'hFFF, -1, 2'd0, 12'd0, "R2 all ones");
        frame(12'h801, 2, 2'd0, 12'd1, "R2 then deskew");
        frame(12'h123, 1, 2'd0, 12'd2, "R5 deskew");
        frame(12'hFFF, 4, 2'd1, 12'h9C3, "R6 sync");
        frame(12'h000, 0, 2'd0, 12'd3, "R6 sync again");
        frame(12'h456, 3, 2'd2, 12'h003, "R7 custom");
        frame(12'h789, 0, 2'd3, 12'h001, "R9 reserved ignored");
        frame(12'hABC, 2, 2'd0, 12'd0, "R8 custom kept");
        frame(12'h3C7, -1, 2'd0, 12'd0, "R4 normal back");
        idle_cycle("R10 idle gap");
        idle_cycle("R10 idle gap 2");
        frame(12'h0F0, -1, 2'd0, 12'd0, "R10 restart");
        for (int n = 0; n < 60; n++) begin
            logic [11:0] d;
            int wk;
            d  = 12'($urandom);
            wk = int'($urandom % 8) - 3;
            if (wk > 4) wk = -1;
            frame(d, wk, 2'($urandom), 12'($urandom), "R8 random");
            if (($urandom % 10) == 0) idle_cycle("R10 random gap");
        end
        idle_cycle("R10 final idle");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule